// File: doc/BRIEF.md
# I2C Controller Status Flag Unit

This block holds the eight-bit status word of an I2C controller. It samples the raw SCL and SDA lines through synchronisers and finds START and STOP conditions on them. It counts SCL clocks to locate the ninth clock of each byte. It also compares each received calling address against the controller's own address, and accepts address zero as a broadcast when that is enabled. Event strobes from the surrounding shift engine tell it when an address byte has arrived and when arbitration was lost. Level inputs tell it whether the controller is transmitting and whether it is bus master.

Software reaches the status word through a small register port. The status word sits at offset 0x0C. Writes to the control register at offset 0x08 and to the data register at offset 0x10 matter here only as clearing events, because those registers live elsewhere. An interrupt output reports the pending flag, gated by an enable input.

Status bit positions, from bit 7 down to bit 0:
- bit 7: transfer done
- bit 6: addressed as target
- bit 5: bus busy
- bit 4: arbitration lost
- bit 3: broadcast hit
- bit 2: target read/write
- bit 1: interrupt pending
- bit 0: received acknowledge (1 means not acknowledged)

Top module: `i2c_stat_flags`

## Requirements
- R1: After a synchronous reset, the status word is 0x81. A read at offset 0x0C returns the status word on `reg_rdata_o` one clock after the request. A read at any other offset returns 0x00.
- R2: A START (SDA falls while SCL is high) sets bit 5. A STOP (SDA rises while SCL is high) clears bit 5.
- R3: Bit 7 stays low through the bits of a byte, including the ninth SCL rising edge. It goes high on the ninth SCL falling edge counted from the START.
- R4: Three events clear bit 7: a status read while `tx_mode_i`=0, a write to offset 0x10 while `tx_mode_i`=1, and a START while `master_i`=0. A status read while `tx_mode_i`=1 does not clear it. Neither does a START while `master_i`=1.
- R5: `addr_byte_stb_i` sets bit 6 when `addr_byte_i[7:1]` is nonzero and equals `own_addr_i`. It also sets bit 6 when `addr_byte_i[7:1]` is zero and `bcast_en_i`=1. On such a match, bit 3 takes 1 for the zero address and 0 otherwise, and bit 2 takes `addr_byte_i[0]`. A zero address with `bcast_en_i`=0 changes nothing.
- R6: Any write to offset 0x08 clears bit 6.
- R7: `arb_lost_stb_i` sets bit 4. Only a status write with bit 4 = 0 clears it.
- R8: Bit 1 is set when bit 7, bit 6 or bit 4 rises. A status write with bit 1 = 0 clears it. Writing 1 to bit 4 or bit 1 has no effect. Status writes leave bits 7, 6, 5, 3, 2 and 0 unchanged.
- R9: Bit 0 takes the synchronised SDA level on the ninth SCL rising edge of each byte.
- R10: `irq_o` is registered. It is high exactly when bit 1 is set and `irq_en_i` was high at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| tx_mode_i | input | 1 | 1 = transmit mode, 0 = receive mode |
| master_i | input | 1 | 1 = bus master, 0 = target |
| bcast_en_i | input | 1 | Accept calling address zero |
| own_addr_i | input | 7 | Programmed own address |
| addr_byte_stb_i | input | 1 | Address byte received strobe |
| addr_byte_i | input | 8 | Received address byte: address in [7:1], read/write in [0] |
| arb_lost_stb_i | input | 1 | Arbitration lost strobe |
| reg_en_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, one clock after the request |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check every cycle that START and STOP drive the busy flag. They also check that a ninth falling edge sets the done flag, that a control write removes the target flag, and that a zero address without broadcast enable is rejected. Further cycle checks cover arbitration-lost holding until software clears it, interrupt sources raising the pending bit, and the interrupt output never being high without the pending bit. Only the bench scenarios can show the conditional clearing of the done flag by reads and writes in each mode, and the values latched into the read/write, broadcast and acknowledge bits. The same holds for the exhaustive address sweep over both own-address choices, broadcast settings and read/write values.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned SB_DONE = 7;
  localparam int unsigned SB_AAS  = 6;
  localparam int unsigned SB_BUSY = 5;
  localparam int unsigned SB_ARBL = 4;
  localparam int unsigned SB_BCST = 3;
  localparam int unsigned SB_SRW  = 2;
  localparam int unsigned SB_IPND = 1;
  localparam int unsigned SB_NACK = 0;
  localparam int unsigned STAT_W  = 8;
  localparam logic [STAT_W-1:0] STAT_RST = 8'h81;
  localparam logic [STAT_W-1:0] STAT_WMASK = 8'h12;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic         scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_i};
      sda_sh <= {sda_sh[TOP-1:0], sda_i};
      scl_d  <= scl_sh[TOP];
      sda_d  <= sda_sh[TOP];
    end
  end

  assign scl_s    = scl_sh[TOP];
  assign sda_s    = sda_sh[TOP];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_o  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_bit_ctr.sv
module i2c_bit_ctr #(
  parameter int unsigned BITS_PER_XFER = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic last_rise_o,
  output logic last_fall_o
);
  localparam int unsigned CW = $clog2(BITS_PER_XFER + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS_PER_XFER);
  localparam logic [CW-1:0] PREV = CW'(BITS_PER_XFER - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start_i || stop_i) cnt <= '0;
    else if (scl_rise) cnt <= (cnt == LAST) ? CW'(1) : cnt + CW'(1);
  end

  assign last_rise_o = scl_rise & (cnt == PREV);
  assign last_fall_o = scl_fall & (cnt == LAST);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              bcast_en_i,
  input  logic [ADDR_W:0]   addr_byte_i,
  output logic              hit_o,
  output logic              bcast_o
);
  logic [ADDR_W-1:0] call;

  assign call    = addr_byte_i[ADDR_W:1];
  assign bcast_o = (call == '0);
  assign hit_o   = bcast_o ? bcast_en_i : (call == own_addr_i);
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
#(
  parameter int unsigned ADDR_W        = 7,
  parameter int unsigned REG_AW        = 5,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned BITS_PER_XFER = 9,
  parameter logic [REG_AW-1:0] CTRL_OFS = 5'h08,
  parameter logic [REG_AW-1:0] STAT_OFS = 5'h0C,
  parameter logic [REG_AW-1:0] DATA_OFS = 5'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              tx_mode_i,
  input  logic              master_i,
  input  logic              bcast_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr_byte_stb_i,
  input  logic [ADDR_W:0]   addr_byte_i,
  input  logic              arb_lost_stb_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  input  logic              irq_en_i,
  output logic              irq_o
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic ninth_rise, ninth_fall, addr_hit, addr_bcast;
  logic stat_wr, stat_rd, ctrl_wr, data_wr;
  logic [STAT_W-1:0] stat_q, stat_n;
  logic irq_n;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  i2c_bit_ctr #(.BITS_PER_XFER(BITS_PER_XFER)) u_cnt (
    .clk(clk), .rst(rst), .start_i(start_evt), .stop_i(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .last_rise_o(ninth_rise), .last_fall_o(ninth_fall)
  );

  i2c_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .own_addr_i(own_addr_i), .bcast_en_i(bcast_en_i), .addr_byte_i(addr_byte_i),
    .hit_o(addr_hit), .bcast_o(addr_bcast)
  );

  assign stat_wr = reg_en_i &  reg_we_i & (reg_addr_i == STAT_OFS);
  assign stat_rd = reg_en_i & ~reg_we_i & (reg_addr_i == STAT_OFS);
  assign ctrl_wr = reg_en_i &  reg_we_i & (reg_addr_i == CTRL_OFS);
  assign data_wr = reg_en_i &  reg_we_i & (reg_addr_i == DATA_OFS);

  always_comb begin
    stat_n = stat_q;
    // software may only clear the writable bits
    if (stat_wr) stat_n = stat_n & (reg_wdata_i | ~STAT_WMASK);
    // transfer done
    if ((stat_rd && !tx_mode_i) || (data_wr && tx_mode_i) || (start_evt && !master_i))
      stat_n[SB_DONE] = 1'b0;
    if (ninth_fall) stat_n[SB_DONE] = 1'b1;
    // addressed as target
    if (ctrl_wr) stat_n[SB_AAS] = 1'b0;
    if (addr_byte_stb_i && addr_hit) begin
      stat_n[SB_AAS]  = 1'b1;
      stat_n[SB_BCST] = addr_bcast;
      stat_n[SB_SRW]  = addr_byte_i[0];
    end
    // bus busy
    if (start_evt)     stat_n[SB_BUSY] = 1'b1;
    else if (stop_evt) stat_n[SB_BUSY] = 1'b0;
    // arbitration lost
    if (arb_lost_stb_i) stat_n[SB_ARBL] = 1'b1;
    // acknowledge sample
    if (ninth_rise) stat_n[SB_NACK] = sda_s;
    // interrupt pending on any rising source
    if ((stat_n[SB_DONE] & ~stat_q[SB_DONE]) |
        (stat_n[SB_AAS]  & ~stat_q[SB_AAS])  |
        (stat_n[SB_ARBL] & ~stat_q[SB_ARBL]))
      stat_n[SB_IPND] = 1'b1;
    irq_n = stat_n[SB_IPND] & irq_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q      <= STAT_RST;
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      stat_q <= stat_n;
      irq_o  <= irq_n;
      if (reg_en_i && !reg_we_i)
        reg_rdata_o <= (reg_addr_i == STAT_OFS) ? stat_q : '0;
    end
  end
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk
  import i2c_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [STAT_W-1:0] stat,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              ninth_fall,
  input logic              stat_wr,
  input logic              ctrl_wr,
  input logic              addr_byte_stb_i,
  input logic [ADDR_W:0]   addr_byte_i,
  input logic              bcast_en_i,
  input logic              arb_lost_stb_i,
  input logic              irq_o
);
  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> stat[SB_BUSY]);
  // R2
  busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !start_evt) |=> !stat[SB_BUSY]);
  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    ninth_fall |=> stat[SB_DONE]);
  // R6
  aas_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !addr_byte_stb_i) |=> !stat[SB_AAS]);
  // R5
  bcast_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_byte_stb_i && addr_byte_i[ADDR_W:1] == '0 && !bcast_en_i && !stat[SB_AAS])
      |=> !stat[SB_AAS]);
  // R7
  arbl_set_chk: assert property (@(posedge clk) disable iff (rst)
    arb_lost_stb_i |=> stat[SB_ARBL]);
  // R7
  arbl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[SB_ARBL] && !stat_wr) |=> stat[SB_ARBL]);
  // R8
  ipnd_src_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(stat[SB_DONE]) || $rose(stat[SB_AAS]) || $rose(stat[SB_ARBL])) |-> stat[SB_IPND]);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> stat[SB_IPND]);
endmodule

bind i2c_stat_flags i2c_stat_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .stat(stat_q), .start_evt(start_evt), .stop_evt(stop_evt),
  .ninth_fall(ninth_fall), .stat_wr(stat_wr), .ctrl_wr(ctrl_wr),
  .addr_byte_stb_i(addr_byte_stb_i), .addr_byte_i(addr_byte_i),
  .bcast_en_i(bcast_en_i), .arb_lost_stb_i(arb_lost_stb_i), .irq_o(irq_o)
);

// File: tb/sim_i2c_stat_flags.sv
module sim_i2c_stat_flags;
  localparam logic [4:0] OFS_CTRL = 5'h08, OFS_STAT = 5'h0C, OFS_DATA = 5'h10;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, tx_mode = 1'b1, master = 1'b0, bcast_en = 1'b0;
  logic [6:0] own = 7'h2A;
  logic addr_stb = 1'b0, al_stb = 1'b0;
  logic [7:0] addr_byte = '0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq_en = 1'b0, irq;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  i2c_stat_flags u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .tx_mode_i(tx_mode),
    .master_i(master), .bcast_en_i(bcast_en), .own_addr_i(own),
    .addr_byte_stb_i(addr_stb), .addr_byte_i(addr_byte), .arb_lost_stb_i(al_stb),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_en_i(irq_en), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_scl(input logic v); scl = v; tick(4); endtask
  task automatic line_sda(input logic v); sda = v; tick(4); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_en = 0; d = rdata;
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(OFS_STAT, v);
    chk(req, v, exp);
  endtask

  // eight data bits then the acknowledge bit; stops before the ninth fall
  task automatic byte_to_ninth_rise(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      line_scl(0); line_sda(b[i]); line_scl(1);
    end
    line_scl(0); line_sda(ack); line_scl(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic m, bcb, srw;
    tick(5); rst = 0; tick(6);
    // R1 reset value and read decode
    chk_stat("R1 reset", 8'h81);
    rd(5'h04, v); chk("R1 other offset", v, 8'h00);
    chk("R10 irq idle", {7'd0, irq}, 8'h00);

    // R2 start sets busy, R4 start as target clears done
    line_sda(0);
    chk_stat("R2/R4 start as target", 8'h21);

    // R3 / R9 first byte, acknowledged
    byte_to_ninth_rise(8'hA5, 1'b0);
    chk_stat("R3 low at ninth rise, R9 ack", 8'h20);
    line_scl(0);
    chk_stat("R3 done on ninth fall, R8 pending", 8'hA2);

    // R10 interrupt gating
    chk("R10 irq disabled", {7'd0, irq}, 8'h00);
    irq_en = 1; tick(2);
    chk("R10 irq enabled", {7'd0, irq}, 8'h01);
    wr(OFS_STAT, 8'h00); tick(1);
    chk("R10 irq after clear", {7'd0, irq}, 8'h00);
    chk_stat("R4 tx read keeps done", 8'hA0);
    tx_mode = 0;
    chk_stat("R4 rx read returns old value", 8'hA0);
    tx_mode = 1;
    chk_stat("R4 rx read cleared done", 8'h20);

    // second byte as master, not acknowledged
    master = 1;
    byte_to_ninth_rise(8'h3C, 1'b1);
    chk_stat("R3 low at ninth rise, R9 nack", 8'h21);
    line_scl(0);
    chk_stat("R3 done second byte", 8'hA3);
    // repeated start as master keeps done
    line_sda(1); line_scl(1); line_sda(0);
    chk_stat("R4 start as master keeps done", 8'hA3);
    wr(OFS_DATA, 8'h55);
    chk_stat("R4 data write in tx clears done", 8'h23);
    wr(OFS_STAT, 8'h00);
    chk_stat("R8 pending cleared", 8'h21);
    master = 0;

    // R7 arbitration lost
    @(negedge clk); al_stb = 1; @(negedge clk); al_stb = 0;
    chk_stat("R7 set, R8 pending", 8'h33);
    wr(OFS_CTRL, 8'h00);
    chk_stat("R7 ctrl write keeps", 8'h33);
    wr(OFS_STAT, 8'h12);
    chk_stat("R8 write ones no effect", 8'h33);
    wr(OFS_STAT, 8'hFF);
    chk_stat("R8 read-only bits ignore writes", 8'h33);
    wr(OFS_STAT, 8'h02);
    chk_stat("R7 software clear", 8'h23);
    wr(OFS_STAT, 8'h00);
    chk_stat("R8 clear pending", 8'h21);

    // R5 / R6 exhaustive address sweep
    bcb = 0; srw = 0;
    for (int o = 0; o < 2; o++) begin
      own = (o == 0) ? 7'h2A : 7'h00;
      for (int b = 0; b < 2; b++) begin
        bcast_en = b[0];
        for (int a = 0; a < 128; a++) begin
          for (int r = 0; r < 2; r++) begin
            wr(OFS_CTRL, 8'h00);
            wr(OFS_STAT, 8'h10);
            @(negedge clk); addr_byte = {a[6:0], r[0]}; addr_stb = 1;
            @(negedge clk); addr_stb = 0;
            m = (a == 0) ? b[0] : (a[6:0] == own);
            if (m) begin bcb = (a == 0); srw = r[0]; end
            chk_stat("R5 address match",
                     {1'b0, m, 1'b1, 1'b0, bcb, srw, m, 1'b1});
          end
        end
      end
    end
    wr(OFS_STAT, 8'h00);
    wr(OFS_CTRL, 8'h00);
    chk_stat("R6 ctrl write clears target flag", {4'b0010, bcb, srw, 2'b01});

    // R2 stop clears busy (SCL is high, SDA low)
    line_sda(1);
    chk_stat("R2 stop", {4'b0000, bcb, srw, 2'b01});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule